// File: doc/BRIEF.md
# Pin-Sequence Detection Mode Controller

This controller sits beside the serial/latch datapath of a multi-channel constant-current sink driver. It watches the latch and output-enable control pins on every rising clock edge and decides whether the driver is in normal display mode or in fault-detection mode. No register write is involved. The mode changes only when a fixed five-edge pattern appears on the two dual-purpose pins. The entry pattern and the exit pattern have the same enable shape. They differ in one latch-high sample, which only the entry pattern has.

Once detection mode is active, the controller tells the datapath when serial data can be sampled. It then watches the enable pin for the evaluation interval, in which the enable is low. When the enable returns high it issues a single-cycle capture strobe so that the datapath loads the per-channel fault results. A parameterised minimum low time, counted in clock cycles, raises a flag alongside the capture if the evaluation interval was too short. The capture is still issued in that case. Entry and exit must strictly alternate, so a new detection always needs an exit first.

Sample order is oldest first. In the patterns below, H means 1 and L means 0. All control and status pins are plain levels or pulses; there is no streaming interface.

Top module: `dmseq_ctrl`

## Requirements
- R1: After reset the mode is normal, every output is 0 and the pattern history is empty. Samples taken before a reset can never complete a pattern afterwards.
- R2: In normal mode, the following five consecutive edges switch detect_mode_o to 1 in the cycle after the fifth edge:
  - enable samples H, L, H, H, H;
  - latch samples L, L, L, H, L.
- R3: sdi_ready_o is 1 from the cycle after the entry pattern completes, so the sixth edge may sample serial data. It falls after the first edge that samples the enable low in detection mode, and it stays 0 until the next entry.
- R4: In detection mode, enable samples H, L, H, H, H with the latch low on all five edges return detect_mode_o to 0 in the cycle after the fifth edge.
- R5: An exit pattern received in normal mode leaves detect_mode_o at 0.
- R6: An entry pattern received in detection mode leaves detect_mode_o at 1.
- R7: Matching considers every five-edge window, so a pattern that begins part-way through a failed attempt is still recognised.
- R8: capture_o is a one-cycle pulse in the cycle after the first edge that samples the enable high following at least one low sample in detection mode.
- R9: At most one capture occurs per detection-mode entry. Later low/high enable activity gives no capture until an exit and a fresh entry.
- R10: short_eval_o pulses together with capture_o when fewer than MIN_LOW_CYC low samples preceded it. It stays 0 when the count is MIN_LOW_CYC or more. The capture is issued either way.
- R11: Low enable samples taken before detect_mode_o is 1, including the one inside the entry pattern itself, do not count toward the evaluation interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; the pins are read on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| le_i | input | 1 | Latch pin level (dual-purpose pattern input) |
| oe_i | input | 1 | Output-enable pin level, active low (dual-purpose pattern input) |
| detect_mode_o | output | 1 | 1 while in fault-detection mode |
| sdi_ready_o | output | 1 | Serial data may be sampled for detection |
| capture_o | output | 1 | One-cycle strobe to load fault status |
| short_eval_o | output | 1 | Evaluation interval was shorter than MIN_LOW_CYC (pulses with capture) |

## Verification
Two functions can land on the same edge: the capture strobe and the too-short flag. The bench provokes this by holding the enable low for fewer cycles than the minimum and then raising it. It expects both pulses in the same cycle. A second case raises the enable after exactly the minimum number of low samples. There the bench expects the capture with the flag clear.

A second coincidence comes from an entry pattern sent while detection is already active. The low enable sample inside that pattern also starts an evaluation. The bench therefore judges three things on their exact cycles:
- that the capture happens;
- that the mode is held;
- that the pattern is refused.

// File: rtl/dmseq_pkg.sv
package dmseq_pkg;
  // Number of consecutive edges that make one mode-change pattern.
  localparam int PAT_LEN = 5;

  // Pattern bit k is the k-th sample in time, bit 0 oldest.
  localparam logic [PAT_LEN-1:0] ENTRY_OE = 5'b11101;
  localparam logic [PAT_LEN-1:0] ENTRY_LE = 5'b01000;
  localparam logic [PAT_LEN-1:0] EXIT_OE  = 5'b11101;
  localparam logic [PAT_LEN-1:0] EXIT_LE  = 5'b00000;

  // Index of each pattern in the matcher bank.
  localparam int PAT_ENTRY = 0;
  localparam int PAT_EXIT  = 1;
  localparam int N_PAT     = 2;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_DETECT = 1'b1
  } mode_e;

  typedef struct packed {
    logic oe;
    logic le;
  } pin_smp_t;
endpackage

// File: rtl/dmseq_win_match.sv
module dmseq_win_match
  import dmseq_pkg::*;
#(
  parameter int LEN  = PAT_LEN,
  parameter int NPAT = N_PAT
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  pin_smp_t                  smp_i,
  input  logic [NPAT-1:0][LEN-1:0]  pat_oe_i,
  input  logic [NPAT-1:0][LEN-1:0]  pat_le_i,
  output logic [NPAT-1:0]           hit_o
);
  // The stored depth is one less than the pattern: the current edge's
  // sample completes the window combinationally.
  localparam int DEPTH = LEN - 1;

  pin_smp_t         hist_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [LEN-1:0]   win_oe;
  logic [LEN-1:0]   win_le;
  logic             full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int k = 0; k < DEPTH; k++) hist_q[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        hist_q[k] <= hist_q[k+1];
        vld_q[k]  <= vld_q[k+1];
      end
      hist_q[DEPTH-1] <= smp_i;
      vld_q[DEPTH-1]  <= 1'b1;
    end
  end

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_win
      assign win_oe[k] = hist_q[k].oe;
      assign win_le[k] = hist_q[k].le;
    end
  endgenerate

  assign win_oe[LEN-1] = smp_i.oe;
  assign win_le[LEN-1] = smp_i.le;

  // Stages fill in order, so the oldest valid bit covers the whole window.
  assign full = vld_q[0];

  generate
    for (genvar p = 0; p < NPAT; p++) begin : g_pat
      assign hit_o[p] = full && (win_oe == pat_oe_i[p]) && (win_le == pat_le_i[p]);
    end
  endgenerate

  // R1: until the window is filled after reset, no pattern can complete.
  p_empty_no_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q[0] |-> (hit_o == '0));
endmodule

// File: rtl/dmseq_mode_ctl.sv
module dmseq_mode_ctl
  import dmseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  entry_hit_i,
  input  logic  exit_hit_i,
  output mode_e mode_o
);
  mode_e mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NORMAL;
    end else begin
      unique case (mode_q)
        MODE_NORMAL: if (entry_hit_i) mode_q <= MODE_DETECT;
        MODE_DETECT: if (exit_hit_i)  mode_q <= MODE_NORMAL;
        default:     mode_q <= MODE_NORMAL;
      endcase
    end
  end

  assign mode_o = mode_q;

  p_entry_enters_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_NORMAL && entry_hit_i) |=> (mode_q == MODE_DETECT));
  p_exit_leaves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DETECT && exit_hit_i) |=> (mode_q == MODE_NORMAL));
  p_exit_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_NORMAL && !entry_hit_i) |=> (mode_q == MODE_NORMAL));
  p_entry_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DETECT && !exit_hit_i) |=> (mode_q == MODE_DETECT));
endmodule

// File: rtl/dmseq_eval.sv
module dmseq_eval #(
  parameter int MIN_LOW_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic detect_i,
  input  logic oe_i,
  output logic low_seen_o,
  output logic capture_o,
  output logic short_o
);
  localparam int              CNT_W   = $clog2(MIN_LOW_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             low_seen_q;
  logic             done_q;
  logic             capture_q;
  logic             short_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      low_seen_q <= 1'b0;
      done_q     <= 1'b0;
      capture_q  <= 1'b0;
      short_q    <= 1'b0;
    end else begin
      capture_q <= 1'b0;
      short_q   <= 1'b0;
      if (!detect_i) begin
        // Outside detection, evaluation state is cleared; nothing counts.
        cnt_q      <= '0;
        low_seen_q <= 1'b0;
        done_q     <= 1'b0;
      end else if (!done_q) begin
        if (!oe_i) begin
          low_seen_q <= 1'b1;
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
        end else if (low_seen_q) begin
          capture_q <= 1'b1;
          short_q   <= (cnt_q < CNT_MAX);
          done_q    <= 1'b1;
        end
      end
    end
  end

  assign low_seen_o = low_seen_q;
  assign capture_o  = capture_q;
  assign short_o    = short_q;

  p_capture_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture_q |=> !capture_q);
  p_capture_after_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture_q |-> low_seen_q);
  p_single_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && detect_i) |=> !capture_q);
  p_short_with_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    short_q |-> capture_q);
endmodule

// File: rtl/dmseq_ctrl.sv
module dmseq_ctrl
  import dmseq_pkg::*;
#(
  parameter int MIN_LOW_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic le_i,
  input  logic oe_i,
  output logic detect_mode_o,
  output logic sdi_ready_o,
  output logic capture_o,
  output logic short_eval_o
);
  localparam logic [N_PAT-1:0][PAT_LEN-1:0] PAT_OE = {EXIT_OE, ENTRY_OE};
  localparam logic [N_PAT-1:0][PAT_LEN-1:0] PAT_LE = {EXIT_LE, ENTRY_LE};

  pin_smp_t          smp;
  logic [N_PAT-1:0]  hit;
  mode_e             mode;
  logic              detect;
  logic              low_seen;

  assign smp.oe = oe_i;
  assign smp.le = le_i;

  dmseq_win_match #(
    .LEN  (PAT_LEN),
    .NPAT (N_PAT)
  ) i_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_i    (smp),
    .pat_oe_i (PAT_OE),
    .pat_le_i (PAT_LE),
    .hit_o    (hit)
  );

  dmseq_mode_ctl i_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_hit_i (hit[PAT_ENTRY]),
    .exit_hit_i  (hit[PAT_EXIT]),
    .mode_o      (mode)
  );

  assign detect = (mode == MODE_DETECT);

  dmseq_eval #(
    .MIN_LOW_CYC (MIN_LOW_CYC)
  ) i_eval (
    .clk        (clk),
    .rst_n      (rst_n),
    .detect_i   (detect),
    .oe_i       (oe_i),
    .low_seen_o (low_seen),
    .capture_o  (capture_o),
    .short_o    (short_eval_o)
  );

  assign detect_mode_o = detect;
  assign sdi_ready_o   = detect && !low_seen;

  p_ready_on_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(detect_mode_o) |-> sdi_ready_o);
  p_capture_in_detect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |-> detect_mode_o);
endmodule

// File: tb/test_dmseq_ctrl.sv
module test_dmseq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic le_r = 1'b0;
  logic oe_r = 1'b1;
  logic det, rdy, cap, sh;
  int   n_chk = 0;
  int   n_err = 0;

  always #4 clk = ~clk; // 125 MHz

  dmseq_ctrl #(.MIN_LOW_CYC(4)) i_dmseq_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .le_i          (le_r),
    .oe_i          (oe_r),
    .detect_mode_o (det),
    .sdi_ready_o   (rdy),
    .capture_o     (cap),
    .short_eval_o  (sh)
  );

  // Fields: [5] enable, [4] latch, then expected {detect, ready, capture, short}
  localparam logic [5:0] VEC [17] = '{
    6'b10_0000, 6'b00_0000, 6'b10_0000, 6'b11_0000, 6'b10_1100,
    6'b10_1100, 6'b00_1000, 6'b00_1000, 6'b10_1011, 6'b10_1000,
    6'b00_1000, 6'b10_1000, 6'b10_1000, 6'b00_1000, 6'b10_1000,
    6'b10_1000, 6'b10_0000
  };

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic drive(input logic oe, input logic le);
    oe_r = oe;
    le_r = le;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {det, rdy, cap, sh};
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", 4'b0000);
    rst_n = 1'b1;
    // R1: four entry samples before a reset must not survive it
    drive(1, 0); drive(0, 0); drive(1, 0); drive(1, 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(1, 0);
    chk("R1 history emptied by reset", 4'b0000);

    // Table: entry (R2), ready (R3), short capture (R8, R10), single capture (R9), exit (R4)
    for (int i = 0; i < 17; i++) begin
      drive(VEC[i][5], VEC[i][4]);
      chk($sformatf("R2/R3/R8/R9/R4 table step %0d", i), VEC[i][3:0]);
    end

    // R5: exit pattern in normal mode is ignored
    drive(1, 0); drive(0, 0); drive(1, 0); drive(1, 0); drive(1, 0);
    chk("R5 exit ignored in normal", 4'b0000);

    // R7: failed attempt, then a pattern starting part-way through
    drive(1, 0); drive(0, 0); drive(1, 0); drive(0, 0); drive(1, 0);
    drive(1, 1);
    chk("R7 no entry before window completes", 4'b0000);
    drive(1, 0);
    chk("R7 overlapped entry recognised", 4'b1100);

    // R6: entry pattern while in detection is refused; its low sample evaluates
    drive(1, 0);
    chk("R6 step1", 4'b1100);
    drive(0, 0);
    chk("R3 ready falls on first low", 4'b1000);
    drive(1, 0);
    chk("R8/R10 capture with short flag", 4'b1011);
    drive(1, 1);
    chk("R8 capture one cycle", 4'b1000);
    drive(1, 0);
    chk("R6 entry ignored in detect", 4'b1000);
    drive(0, 0); drive(1, 0);
    chk("R9 no second capture", 4'b1000);

    // R4: exit
    drive(1, 0); drive(0, 0); drive(1, 0); drive(1, 0);
    chk("R4 still detect before fifth edge", 4'b1000);
    drive(1, 0);
    chk("R4 exit to normal", 4'b0000);

    // R11: entry's own low must not count: 3 lows after entry -> short
    drive(1, 0); drive(0, 0); drive(1, 0); drive(1, 1); drive(1, 0);
    chk("R11 entered", 4'b1100);
    drive(0, 0); drive(0, 0); drive(0, 0);
    chk("R11 low phase", 4'b1000);
    drive(1, 0);
    chk("R11 three lows flagged short", 4'b1011);
    drive(1, 0); drive(0, 0); drive(1, 0); drive(1, 0); drive(1, 0);
    chk("R4 second exit", 4'b0000);

    // R10: exactly MIN_LOW_CYC lows -> capture without short flag
    drive(1, 0); drive(0, 0); drive(1, 0); drive(1, 1); drive(1, 0);
    chk("R2 re-entry after exit", 4'b1100);
    drive(0, 0); drive(0, 0); drive(0, 0); drive(0, 0);
    drive(1, 0);
    chk("R10 boundary capture not short", 4'b1010);
    drive(1, 0);
    chk("R8 pulse cleared", 4'b1000);

    finish_run();
  end
endmodule